// File: doc/BRIEF.md
# Scan Launch-Capture Test Sequencer

This controller runs one two-pattern delay test through a single scan chain. All timing comes from counters on one fast base clock. Every scan-cell clock edge appears as a one-cycle enable pulse on `clk_en_o`. Shift edges are spaced by a programmable slow period. Only the gap between the launch edge and the capture edge uses the shorter rated period, so that gap is the only interval that tests the timing of the logic under test.

A start pulse latches the configuration and the first vector. The controller then runs five steps:

- It shifts the first vector into the chain in scan mode.
- It launches the second vector, in one of two ways. Shift launch applies one more scan shift, with `scan_en_o` still high. Functional launch applies one system edge in normal mode.
- It captures the response in normal mode, one rated period after the launch edge.
- It returns to scan mode.
- It shifts the response out and collects it into a parallel word.

Strobes on `pi_v1_o` and `pi_v2_o` tell the tester when to change the primary inputs to the first and the second vector.

Top module: `scan_launch_capture_seq`

## Requirements
- R1: During and after reset with no start: `busy_o`=0, `clk_en_o`=0, `done_o`=0, `pi_v1_o`=`pi_v2_o`=0, and `scan_en_o`=1 (scan mode).
- R2: Load phase. The k-th enable pulse (k=1..L, where L is the chain length, 1..MAX_LEN) comes k·S cycles after the cycle in which start was sampled. S is the slow period. During each of these pulses `scan_en_o`=1 and `scan_in_o` = bit k-1 of `vec_i`.
- R3: With `func_launch_i`=0 sampled at start, the launch pulse comes S cycles after the last load pulse. It has `scan_en_o`=1 and `scan_in_o` = bit L of `vec_i`.
- R4: With `func_launch_i`=1 sampled at start, the launch pulse comes S cycles after the last load pulse, with `scan_en_o`=0.
- R5: The capture pulse comes exactly P cycles after the launch pulse, where P is the rated period (1 ≤ P < S). `scan_en_o` is 0 in every cycle from the one after the launch pulse through the capture pulse.
- R6: Unload phase. L pulses follow, the first one S cycles after capture and the rest S apart, all with `scan_en_o`=1. Bit k of `resp_o` holds `scan_out_i` as sampled at unload pulse k+1. Bits at L and above read 0.
- R7: `pi_v1_o` pulses only together with the last load pulse. `pi_v2_o` pulses only together with the launch pulse.
- R8: `busy_o` is 1 from the cycle after start through the last unload pulse. `clk_en_o` never pulses while idle. `done_o` is a one-cycle pulse in the first idle cycle.
- R9: A start pulse received while busy is ignored. Mode, length, periods and vector are latched at start, so changes on those inputs during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| func_launch_i | input | 1 | 0 = shift launch, 1 = functional launch |
| chain_len_i | input | LEN_W | Number of scan cells, 1..MAX_LEN |
| shift_period_i | input | PER_W | Slow shift period, in base cycles (≥2) |
| rated_period_i | input | PER_W | Launch-to-capture period, in base cycles (≥1, below the shift period) |
| vec_i | input | MAX_LEN+1 | First vector. Bit L is the extra bit shifted in at a shift launch |
| scan_out_i | input | 1 | Serial data from the end of the chain |
| scan_en_o | output | 1 | Test control: 1 = scan mode, 0 = normal mode |
| clk_en_o | output | 1 | One-cycle scan-cell clock enable |
| scan_in_o | output | 1 | Serial data into the chain |
| pi_v1_o | output | 1 | Strobe to apply the first primary-input vector |
| pi_v2_o | output | 1 | Strobe to apply the second primary-input vector |
| resp_o | output | MAX_LEN | Collected response |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |

## Verification
A wrong phase or a miscounted bit index shows up at the ports within one slow period. It appears as an enable pulse on the wrong cycle, a wrong level on `scan_en_o` at that pulse, or a misplaced strobe. A wrong period reload shifts every later pulse and is caught at the next edge. A mismatch in the shift data or in the response bit order only appears in `resp_o` at the end of the run. For that reason the bench models a chain and a simple combinational function, and compares the collected word with a value it computes on its own.

// File: rtl/scan_seq_pkg.sv
// Package: shared phase encoding for the launch-capture sequencer.
// Assumes nothing beyond a 3-bit state field.
package scan_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_LAUNCH = 3'd2,
        PH_CAPT   = 3'd3,
        PH_UNLOAD = 3'd4
    } phase_t;
endpackage

// File: rtl/seq_period_timer.sv
// Down-counter that produces a one-cycle tick every programmed number of base cycles.
// Assumes period_i >= 1. The owner reloads it on start and on every tick.
module seq_period_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             run_i,
    output logic             tick_o
);
    logic [PER_W-1:0] cnt_q;

    // Count the remaining cycles down to the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload_i)
            cnt_q <= period_i - 1'b1;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/seq_vector_shifter.sv
// Holds the first vector for serial scan-in and assembles the serial scan-out response.
// Assumes cap_idx_i < MAX_LEN whenever cap_i is set.
module seq_vector_shifter #(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [MAX_LEN:0]   vec_i,
    input  logic               shift_i,
    output logic               scan_in_o,
    input  logic               cap_i,
    input  logic [LEN_W-1:0]   cap_idx_i,
    input  logic               scan_out_i,
    output logic [MAX_LEN-1:0] resp_o
);
    logic [MAX_LEN:0] sreg_q;

    // Shift the stored vector toward the chain, filling with zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (load_i)
            sreg_q <= vec_i;
        else if (shift_i)
            sreg_q <= {1'b0, sreg_q[MAX_LEN:1]};
    end

    assign scan_in_o = sreg_q[0];

    // One capture flop per response bit, written when its index comes out.
    for (genvar g = 0; g < MAX_LEN; g++) begin : g_resp
        always_ff @(posedge clk) begin
            if (!rst_n || load_i)
                resp_o[g] <= 1'b0;
            else if (cap_i && cap_idx_i == LEN_W'(g))
                resp_o[g] <= scan_out_i;
        end
    end
endmodule

// File: rtl/scan_launch_capture_seq.sv
// Top: sequences load, launch, rated capture and unload of a two-pattern delay test.
// Assumes 1 <= chain length <= MAX_LEN and 1 <= rated period < shift period.
module scan_launch_capture_seq
    import scan_seq_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int PER_W   = 8,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               func_launch_i,
    input  logic [LEN_W-1:0]   chain_len_i,
    input  logic [PER_W-1:0]   shift_period_i,
    input  logic [PER_W-1:0]   rated_period_i,
    input  logic [MAX_LEN:0]   vec_i,
    input  logic               scan_out_i,
    output logic               scan_en_o,
    output logic               clk_en_o,
    output logic               scan_in_o,
    output logic               pi_v1_o,
    output logic               pi_v2_o,
    output logic [MAX_LEN-1:0] resp_o,
    output logic               busy_o,
    output logic               done_o
);
    phase_t           phase_q;
    logic             func_q;
    logic [LEN_W-1:0] len_q;
    logic [PER_W-1:0] slow_q;
    logic [PER_W-1:0] rated_q;
    logic [LEN_W-1:0] nbits_q;
    logic             done_q;
    logic             tick;
    logic             start_ok;
    logic             last_bit;
    logic             reload;
    logic [PER_W-1:0] period_sel;
    logic             shift_en;
    logic             cap_en;

    assign start_ok = start_i && (phase_q == PH_IDLE);
    assign last_bit = (nbits_q == len_q - 1'b1);
    assign busy_o   = (phase_q != PH_IDLE);

    // Choose the spacing to the next edge: rated only after the launch edge.
    always_comb begin
        reload     = start_ok || tick;
        period_sel = slow_q;
        if (start_ok)
            period_sel = shift_period_i;
        else if (phase_q == PH_LAUNCH)
            period_sel = rated_q;
    end

    seq_period_timer #(.PER_W(PER_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload),
        .period_i (period_sel),
        .run_i    (busy_o),
        .tick_o   (tick)
    );

    // Phase sequencing, bit counting and configuration latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            func_q  <= 1'b0;
            len_q   <= '0;
            slow_q  <= '0;
            rated_q <= '0;
            nbits_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (start_i) begin
                    func_q  <= func_launch_i;
                    len_q   <= chain_len_i;
                    slow_q  <= shift_period_i;
                    rated_q <= rated_period_i;
                    nbits_q <= '0;
                    phase_q <= PH_LOAD;
                end
                PH_LOAD: if (tick) begin
                    if (last_bit) begin
                        nbits_q <= '0;
                        phase_q <= PH_LAUNCH;
                    end else begin
                        nbits_q <= nbits_q + 1'b1;
                    end
                end
                PH_LAUNCH: if (tick) phase_q <= PH_CAPT;
                PH_CAPT:   if (tick) phase_q <= PH_UNLOAD;
                PH_UNLOAD: if (tick) begin
                    if (last_bit) begin
                        nbits_q <= '0;
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        nbits_q <= nbits_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Test-control level per phase: normal mode for capture and functional launch.
    always_comb begin
        unique case (phase_q)
            PH_LAUNCH: scan_en_o = !func_q;
            PH_CAPT:   scan_en_o = 1'b0;
            default:   scan_en_o = 1'b1;
        endcase
    end

    assign clk_en_o = tick;
    assign pi_v1_o  = tick && (phase_q == PH_LOAD) && last_bit;
    assign pi_v2_o  = tick && (phase_q == PH_LAUNCH);
    assign shift_en = tick && ((phase_q == PH_LOAD) || (phase_q == PH_LAUNCH && !func_q));
    assign cap_en   = tick && (phase_q == PH_UNLOAD);
    assign done_o   = done_q;

    seq_vector_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_ok),
        .vec_i      (vec_i),
        .shift_i    (shift_en),
        .scan_in_o  (scan_in_o),
        .cap_i      (cap_en),
        .cap_idx_i  (nbits_q),
        .scan_out_i (scan_out_i),
        .resp_o     (resp_o)
    );
endmodule

// File: rtl/scan_seq_checker.sv
// Checker: port-level timing rules of the sequencer, bound to the top module.
// Assumes synchronous active-low reset on rst_n.
module scan_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic clk_en_o,
    input logic scan_en_o,
    input logic pi_v1_o,
    input logic pi_v2_o,
    input logic done_o
);
    assert_idle_scan_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> scan_en_o);
    assert_normal_after_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pi_v2_o |=> !scan_en_o);
    assert_strobe_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pi_v1_o || pi_v2_o) |-> clk_en_o);
    assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pi_v1_o, pi_v2_o}));
    assert_edge_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_o |-> busy_o);
    assert_done_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    assert_run_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind scan_launch_capture_seq scan_seq_checker i_scan_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .clk_en_o  (clk_en_o),
    .scan_en_o (scan_en_o),
    .pi_v1_o   (pi_v1_o),
    .pi_v2_o   (pi_v2_o),
    .done_o    (done_o)
);

// File: tb/test_scan_launch_capture_seq.sv
`timescale 1ns/1ps
module test_scan_launch_capture_seq;
    localparam int MAXL  = 16;
    localparam int PER_W = 8;
    localparam int LEN_W = $clog2(MAXL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             func_launch_i = 1'b0;
    logic [LEN_W-1:0] chain_len_i = '0;
    logic [PER_W-1:0] shift_period_i = '0;
    logic [PER_W-1:0] rated_period_i = '0;
    logic [MAXL:0]    vec_i = '0;
    logic             scan_out_i;
    logic             scan_en_o, clk_en_o, scan_in_o, pi_v1_o, pi_v2_o, busy_o, done_o;
    logic [MAXL-1:0]  resp_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    scan_launch_capture_seq #(.MAX_LEN(MAXL), .PER_W(PER_W)) i_scan_launch_capture_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_launch_i(func_launch_i),
        .chain_len_i(chain_len_i), .shift_period_i(shift_period_i),
        .rated_period_i(rated_period_i), .vec_i(vec_i), .scan_out_i(scan_out_i),
        .scan_en_o(scan_en_o), .clk_en_o(clk_en_o), .scan_in_o(scan_in_o),
        .pi_v1_o(pi_v1_o), .pi_v2_o(pi_v2_o), .resp_o(resp_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // Environment: the combinational logic under test, applied on a normal-mode edge.
    function automatic logic [MAXL-1:0] logic_fn(logic [MAXL-1:0] x, int len);
        logic [MAXL-1:0] y = '0;
        for (int i = 0; i < len; i++)
            y[i] = x[i] ^ x[(i + 1) % len] ^ (i == 0);
        return y;
    endfunction

    // Environment: scan chain; enters at cell len-1, leaves from cell 0.
    logic [MAXL-1:0] chain = '0;
    int              cur_len = 1;
    assign scan_out_i = chain[0];
    always @(posedge clk) begin
        if (clk_en_o) begin
            if (scan_en_o) begin
                logic [MAXL-1:0] nx;
                nx = chain;
                for (int i = 0; i < cur_len - 1; i++) nx[i] = chain[i + 1];
                nx[cur_len - 1] = scan_in_o;
                chain <= nx;
            end else begin
                chain <= logic_fn(chain, cur_len);
            end
        end
    end

    // Expected response word from the requirements.
    function automatic logic [MAXL-1:0] exp_resp(logic [MAXL:0] v, bit fm, int len);
        logic [MAXL-1:0] v1 = '0, v2 = '0;
        for (int i = 0; i < len; i++) v1[i] = v[i];
        if (fm) v2 = logic_fn(v1, len);
        else begin
            for (int i = 0; i < len - 1; i++) v2[i] = v[i + 1];
            v2[len - 1] = v[len];
        end
        return logic_fn(v2, len);
    endfunction

    // Expected cycle of pulse j, counted from the start sample.
    function automatic int exp_cyc(int j, int len, int sp, int rp);
        if (j <= len + 1) return j * sp;
        return (len + 1) * sp + rp + (j - len - 2) * sp;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_one(bit fm, int len, int sp, int rp, logic [MAXL:0] v, bit disturb);
        int pidx = 0;
        int endc = exp_cyc(2 * len + 2, len, sp, rp);
        int busy_bad = 0, pi_bad = 0, gap_bad = 0;
        logic [MAXL-1:0] er = exp_resp(v, fm, len);
        cur_len = len;
        func_launch_i = fm; chain_len_i = LEN_W'(len);
        shift_period_i = PER_W'(sp); rated_period_i = PER_W'(rp); vec_i = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 1; cyc <= endc + 1; cyc++) begin
            if (cyc <= endc && !busy_o) busy_bad++;
            if (clk_en_o) begin
                string rq;
                pidx++;
                if (pidx <= len) rq = "R2";
                else if (pidx == len + 1) rq = fm ? "R4" : "R3";
                else if (pidx == len + 2) rq = "R5";
                else rq = "R6";
                chk(cyc == exp_cyc(pidx, len, sp, rp), rq, cyc, exp_cyc(pidx, len, sp, rp));
                chk(scan_en_o == ((pidx == len + 1) ? !fm : (pidx != len + 2)), rq, scan_en_o,
                    (pidx == len + 1) ? !fm : (pidx != len + 2));
                if (pidx <= len) chk(scan_in_o == v[pidx - 1], "R2", scan_in_o, v[pidx - 1]);
                if (pidx == len + 1 && !fm) chk(scan_in_o == v[len], "R3", scan_in_o, v[len]);
                chk(pi_v1_o == (pidx == len) && pi_v2_o == (pidx == len + 1), "R7",
                    {pi_v1_o, pi_v2_o}, {pidx == len, pidx == len + 1});
            end else begin
                if (pi_v1_o || pi_v2_o) pi_bad++;
                if (pidx == len + 1 && scan_en_o) gap_bad++;
            end
            if (cyc == endc + 1) begin
                chk(done_o && !busy_o, "R8", {done_o, busy_o}, 2'b10);
                chk(pidx == 2 * len + 2, "R6", pidx, 2 * len + 2);
                chk(resp_o == er, disturb ? "R9" : "R6", resp_o, er);
            end
            if (disturb && cyc == 2) begin
                start_i = 1'b1; func_launch_i = !fm; chain_len_i = LEN_W'(1);
                shift_period_i = PER_W'(2); rated_period_i = PER_W'(1); vec_i = ~v;
            end
            if (disturb && cyc == 3) start_i = 1'b0;
            @(negedge clk);
        end
        chk(busy_bad == 0, "R8", busy_bad, 0);
        chk(pi_bad == 0, "R7", pi_bad, 0);
        chk(gap_bad == 0, "R5", gap_bad, 0);
        chk(!done_o && !busy_o && !clk_en_o, "R8", {done_o, busy_o, clk_en_o}, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy_o && !clk_en_o && !done_o && scan_en_o && !pi_v1_o && !pi_v2_o, "R1",
            {busy_o, clk_en_o, done_o, scan_en_o}, 4'b0001);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !clk_en_o && !done_o && scan_en_o, "R1",
            {busy_o, clk_en_o, done_o, scan_en_o}, 4'b0001);
        // Directed corners: shortest chain, tightest periods, full chain, both modes.
        run_one(1'b0, 1, 2, 1, 17'h00001, 1'b0);
        run_one(1'b1, 1, 2, 1, 17'h00001, 1'b0);
        run_one(1'b0, MAXL, 3, 2, 17'h1A5C3, 1'b0);
        run_one(1'b1, MAXL, 5, 1, 17'h0F0F0, 1'b0);
        run_one(1'b0, 5, 4, 3, 17'h0002B, 1'b1);
        run_one(1'b1, 7, 6, 2, 17'h1FF55, 1'b1);
        // Constrained random runs.
        for (int t = 0; t < 24; t++) begin
            int len = 1 + ($urandom % MAXL);
            int rp  = 1 + ($urandom % 6);
            int sp  = rp + 1 + ($urandom % 6);
            run_one(1'($urandom % 2), len, sp, rp, 17'($urandom), 1'($urandom % 4 == 0));
            repeat ($urandom % 3) @(negedge clk);
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule